// File: doc/BRIEF.md
# Nibble-Wide Host Register Port with Hold Handshake

This block is the host side of a small timekeeping peripheral. It sits between a 4-bit parallel processor bus and a bank of sixteen 4-bit registers. Registers 0 to C are calendar and time counters. Registers D to F are control registers.

The block synchronises the bus strobes to the system clock. It latches the register address and the low-active chip select under an address-latch-enable input, and it decides when the part is selected. It drives read data with an output enable and turns a rising write strobe into a one-cycle write pulse toward the register bank. Bits that do not exist in the addressed register are forced to zero on reads and on writes.

The block also owns two control bits. The freeze bit (register D bit 0) holds back the one-second carry into the counters. The sub-second reset bit (register F bit 0) is driven out to the counters. The block also derives the read-only busy flag that tells the host when frozen counters may be touched.

The read port has no back-pressure. The output enable is a plain level, and the write pulse is a single-cycle valid with no ready, so the register bank must accept it in that cycle.

Top module: `nib_bus_if`

## Requirements
- R1: The part is selected only while the synchronised high-active select is 1 and the effective low-active select is 0. While deselected, no output enable and no write pulse appear.
- R2: While the synchronised address-latch-enable is 1 and the high-active select is 1, the address and the low-active select follow the bus pins. Otherwise the values last captured are used. Holding the latch-enable at 1 makes the latch transparent.
- R3: `bus_doe` is 1 exactly when the part is selected, the synchronised read strobe is 0 and the synchronised write strobe is 1. These are two-flop synchronised values, so the enable follows the pins two clocks later. `bus_dout` is 0 whenever `bus_doe` is 0.
- R4: A 0-to-1 change of the synchronised write strobe, while the part is selected and the read strobe is high, gives a one-cycle `wr_stb` with `wr_addr` and masked `wr_data` taken from the bus in that cycle.
- R5: If the read strobe is low when the write strobe rises, no write pulse is produced. The output enable stays 0 while both strobes are low.
- R6: Bits that do not exist read as 0 and are written as 0. Registers 1, 3, 5 and C keep bits 2:0. Register 7 keeps bits 1:0. Register 9 keeps bit 0. All other registers keep all four bits.
- R7: While the freeze bit is 1, `sec_carry` stays 0. When the freeze bit returns to 0, exactly one `sec_carry` pulse appears in the next cycle if one or more `tick_1s` pulses arrived during the freeze. Otherwise `sec_carry` equals `tick_1s`.
- R8: The busy flag (register D bit 1) reads 1 whenever the freeze bit is 0. With the freeze bit at 1, it drops to 0 one cycle after `upd_win` is first seen at 0, and then it stays at 0. It cannot be written: `wr_data` bit 1 is 0 for register D.
- R9: While the synchronised high-active select is 0, the freeze bit and `subsec_rst` are cleared on the next clock.
- R10: Writes to registers 0 to C produce `wr_stb` only while the freeze bit is 1 and the busy flag is 0. Writes to registers D to F are never held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous low-active reset |
| bus_a | input | 4 | Register address from the host |
| cs_lo_n | input | 1 | Low-active select, captured by the latch enable |
| cs_hi | input | 1 | High-active select, independent of the latch enable |
| ale | input | 1 | Address latch enable, tie to 1 when unused |
| rd_n | input | 1 | Low-active read strobe |
| wr_n | input | 1 | Low-active write strobe |
| bus_din | input | 4 | Write data from the host |
| bus_dout | output | 4 | Read data to the host |
| bus_doe | output | 1 | Output enable for the data pins |
| reg_addr | output | 4 | Effective address to the register bank |
| reg_rdata | input | 4 | Read data of the addressed register |
| wr_stb | output | 1 | One-cycle write pulse |
| wr_addr | output | 4 | Address of the write |
| wr_data | output | 4 | Masked write data |
| tick_1s | input | 1 | One-second carry from the prescaler |
| upd_win | input | 1 | Counters are inside their update window |
| sec_carry | output | 1 | Carry delivered to the seconds counter |
| subsec_rst | output | 1 | Sub-second reset control bit |

## Verification
Reads are tried with the latch enable held high and also with a latch-enable pulse followed by changed pins. The pulsed case shows whether the latch really holds its value rather than following the pins. Reads of the narrow registers show the masks. Writes are tried while free, while frozen but still busy, and while frozen and idle, which separates the gating of the time registers from the control registers. Two ticks during a freeze followed by a release show whether the carries are merged into one, deferred, or lost. Overlapping strobes and dropping the high-active select cover the conflict and forced-clear rules.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 4;
  localparam logic [ADDR_W-1:0] A_LAST_TIME = 4'hC;
  localparam logic [ADDR_W-1:0] A_CTRL_HOLD = 4'hD;
  localparam logic [ADDR_W-1:0] A_CTRL_MODE = 4'hF;

  // Bits that physically exist in each register.
  function automatic logic [DATA_W-1:0] rd_mask(input logic [ADDR_W-1:0] a);
    case (a)
      4'h1, 4'h3, 4'h5, 4'hC: rd_mask = 4'b0111;
      4'h7:                   rd_mask = 4'b0011;
      4'h9:                   rd_mask = 4'b0001;
      default:                rd_mask = 4'b1111;
    endcase
  endfunction

  // Writable bits: existing bits minus the read-only busy flag.
  function automatic logic [DATA_W-1:0] wr_mask(input logic [ADDR_W-1:0] a);
    wr_mask = (a == A_CTRL_HOLD) ? 4'b1101 : rd_mask(a);
  endfunction
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= RST_VAL;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/nib_addr_latch.sv
module nib_addr_latch
  import nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic              cs_hi_s,
  input  logic [ADDR_W-1:0] bus_a,
  input  logic              cs_lo_n,
  output logic [ADDR_W-1:0] a_eff,
  output logic              cs0_eff
);
  logic              open_w;
  logic [ADDR_W-1:0] a_q;
  logic              cs0_q;

  assign open_w = ale_s & cs_hi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      cs0_q <= 1'b1;
    end else if (open_w) begin
      a_q   <= bus_a;
      cs0_q <= cs_lo_n;
    end
  end

  assign a_eff   = open_w ? bus_a   : a_q;
  assign cs0_eff = open_w ? cs_lo_n : cs0_q;
endmodule

// File: rtl/nib_hold_ctl.sv
module nib_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_hi_s,
  input  logic wr_hold,
  input  logic wr_mode,
  input  logic din0,
  input  logic tick_1s,
  input  logic upd_win,
  output logic hold,
  output logic busy,
  output logic subsec_rst,
  output logic sec_carry
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= 1'b0;
      busy       <= 1'b1;
      subsec_rst <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (!cs_hi_s)     hold <= 1'b0;
      else if (wr_hold) hold <= din0;

      if (!cs_hi_s)     subsec_rst <= 1'b0;
      else if (wr_mode) subsec_rst <= din0;

      if (!hold)         busy <= 1'b1;
      else if (!upd_win) busy <= 1'b0;

      pend_q <= hold ? (pend_q | tick_1s) : 1'b0;
    end
  end

  // One merged pulse: live tick while free, or the single deferred carry.
  assign sec_carry = ~hold & (tick_1s | pend_q);
endmodule

// File: rtl/nib_bus_if.sv
module nib_bus_if
  import nib_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_a,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              ale,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              tick_1s,
  input  logic              upd_win,
  output logic              sec_carry,
  output logic              subsec_rst
);
  logic              ale_s, cs_hi_s, rd_s, wr_s, wr_prev;
  logic [ADDR_W-1:0] a_eff;
  logic              cs0_eff, sel, rise, time_ok, wr_go;
  logic              hold_w, busy_w;
  logic [DATA_W-1:0] merged;

  nib_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_lo (
    .clk(clk), .rst_n(rst_n), .d({ale, cs_hi}), .q({ale_s, cs_hi_s}));

  nib_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_hi (
    .clk(clk), .rst_n(rst_n), .d({rd_n, wr_n}), .q({rd_s, wr_s}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_s;
  end

  nib_addr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .cs_hi_s(cs_hi_s),
    .bus_a(bus_a), .cs_lo_n(cs_lo_n), .a_eff(a_eff), .cs0_eff(cs0_eff));

  assign sel     = cs_hi_s & ~cs0_eff;
  assign rise    = wr_s & ~wr_prev;
  assign time_ok = (a_eff > A_LAST_TIME) | (hold_w & ~busy_w);
  assign wr_go   = rise & sel & rd_s & time_ok;

  nib_hold_ctl u_hold (
    .clk(clk), .rst_n(rst_n), .cs_hi_s(cs_hi_s),
    .wr_hold(wr_go && a_eff == A_CTRL_HOLD),
    .wr_mode(wr_go && a_eff == A_CTRL_MODE),
    .din0(bus_din[0]), .tick_1s(tick_1s), .upd_win(upd_win),
    .hold(hold_w), .busy(busy_w), .subsec_rst(subsec_rst),
    .sec_carry(sec_carry));

  always_comb begin
    merged = reg_rdata;
    if (a_eff == A_CTRL_HOLD) merged[1:0] = {busy_w, hold_w};
    if (a_eff == A_CTRL_MODE) merged[0]   = subsec_rst;
  end

  assign reg_addr = a_eff;
  assign bus_doe  = sel & ~rd_s & wr_s;
  assign bus_dout = bus_doe ? (merged & rd_mask(a_eff)) : '0;
  assign wr_stb   = wr_go;
  assign wr_addr  = a_eff;
  assign wr_data  = bus_din & wr_mask(a_eff);
endmodule

// File: rtl/nib_bus_if_chk.sv
module nib_bus_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_s,
  input logic       wr_s,
  input logic       cs_hi_s,
  input logic       hold,
  input logic       busy,
  input logic       tick_1s,
  input logic       sec_carry,
  input logic       subsec_rst,
  input logic       bus_doe,
  input logic [3:0] bus_dout,
  input logic [3:0] reg_addr,
  input logic       wr_stb,
  input logic [3:0] wr_addr
);
  p_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_s && !wr_s) |-> !bus_doe);
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && reg_addr == 4'h9) |-> (bus_dout[3:1] == 3'b000));
  p_deferred_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_carry && !tick_1s) |=> !(sec_carry && !tick_1s));
  p_busy_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> busy);
  p_cs1_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hi_s |=> (!hold && !subsec_rst));
  p_time_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr <= 4'hC) |-> (hold && !busy));
endmodule

bind nib_bus_if nib_bus_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_s(rd_s), .wr_s(wr_s), .cs_hi_s(cs_hi_s),
  .hold(hold_w), .busy(busy_w), .tick_1s(tick_1s), .sec_carry(sec_carry),
  .subsec_rst(subsec_rst), .bus_doe(bus_doe), .bus_dout(bus_dout),
  .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_addr(wr_addr));

// File: tb/sim_nib_bus_if.sv
module sim_nib_bus_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_a = 4'h0;
  logic cs_lo_n = 1'b0, cs_hi = 1'b1, ale = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] bus_din = 4'h0;
  logic [3:0] bus_dout, reg_addr, wr_addr, wr_data;
  logic bus_doe, wr_stb, sec_carry, subsec_rst;
  logic [3:0] reg_rdata = 4'hF;
  logic tick_1s = 1'b0, upd_win = 1'b1;

  int errors = 0, checks = 0, cycles = 0, stb_cnt = 0, carry_cnt = 0;
  logic [3:0] rd_val;

  always #5 clk = ~clk;

  nib_bus_if u0 (.*);

  // ---- behavioural reference model ----
  logic [1:0] m_ale, m_cshi, m_rd, m_wr;
  logic m_wr3, m_cs0, m_hold, m_busy, m_pend, m_srst;
  logic [3:0] m_addr;

  function automatic logic [3:0] exist_bits(input logic [3:0] a);
    if (a == 4'h9) return 4'b0001;
    if (a == 4'h7) return 4'b0011;
    if (a == 4'h1 || a == 4'h3 || a == 4'h5 || a == 4'hC) return 4'b0111;
    return 4'b1111;
  endfunction

  function automatic logic e_open();  return m_ale[1] & m_cshi[1]; endfunction
  function automatic logic [3:0] e_addr(); return e_open() ? bus_a : m_addr; endfunction
  function automatic logic e_sel();
    return m_cshi[1] & ~(e_open() ? cs_lo_n : m_cs0);
  endfunction
  function automatic logic e_doe(); return e_sel() & ~m_rd[1] & m_wr[1]; endfunction
  function automatic logic e_wr();
    logic ok;
    ok = (e_addr() >= 4'hD) || (m_hold && !m_busy);
    return m_wr[1] & ~m_wr3 & e_sel() & m_rd[1] & ok;
  endfunction
  function automatic logic [3:0] e_dout();
    logic [3:0] v;
    v = reg_rdata;
    if (e_addr() == 4'hD) v = {v[3:2], m_busy, m_hold};
    if (e_addr() == 4'hF) v = {v[3:1], m_srst};
    return e_doe() ? (v & exist_bits(e_addr())) : 4'h0;
  endfunction
  function automatic logic [3:0] e_wdata();
    logic [3:0] m;
    m = exist_bits(e_addr());
    if (e_addr() == 4'hD) m[1] = 1'b0;
    return bus_din & m;
  endfunction
  function automatic logic e_carry(); return ~m_hold & (tick_1s | m_pend); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ale <= 2'b00; m_cshi <= 2'b00; m_rd <= 2'b11; m_wr <= 2'b11; m_wr3 <= 1'b1;
      m_addr <= 4'h0; m_cs0 <= 1'b1; m_hold <= 1'b0; m_busy <= 1'b1;
      m_pend <= 1'b0; m_srst <= 1'b0;
    end else begin
      m_ale <= {m_ale[0], ale}; m_cshi <= {m_cshi[0], cs_hi};
      m_rd <= {m_rd[0], rd_n};  m_wr <= {m_wr[0], wr_n}; m_wr3 <= m_wr[1];
      if (e_open()) begin m_addr <= bus_a; m_cs0 <= cs_lo_n; end
      if (!m_cshi[1]) begin m_hold <= 1'b0; m_srst <= 1'b0; end
      else if (e_wr()) begin
        if (e_addr() == 4'hD) m_hold <= bus_din[0];
        if (e_addr() == 4'hF) m_srst <= bus_din[0];
      end
      if (!m_hold) m_busy <= 1'b1;
      else if (!upd_win) m_busy <= 1'b0;
      m_pend <= m_hold ? (m_pend | tick_1s) : 1'b0;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 doe", {3'b0, bus_doe}, {3'b0, e_doe()});
      chk("R6 dout", bus_dout, e_dout());
      chk("R2 addr", reg_addr, e_addr());
      chk("R4 stb", {3'b0, wr_stb}, {3'b0, e_wr()});
      if (wr_stb) chk("R6 wdata", wr_data, e_wdata());
      chk("R7 carry", {3'b0, sec_carry}, {3'b0, e_carry()});
      chk("R9 srst", {3'b0, subsec_rst}, {3'b0, m_srst});
      if (wr_stb) stb_cnt++;
      if (sec_carry) carry_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
    bus_a = a; bus_din = d; wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(4);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [3:0] v);
    bus_a = a; rd_n = 1'b0; cyc(3);
    @(negedge clk); v = bus_dout;
    cyc(1); rd_n = 1'b1; cyc(3);
  endtask

  initial begin
    int s0, c0;
    cyc(3); rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset doe", {3'b0, bus_doe}, 4'h0);
    chk("R9 reset srst", {3'b0, subsec_rst}, 4'h0);
    cyc(3);

    bus_rd(4'hD, rd_val); chk("R8 busy while free", rd_val, 4'hE);
    bus_rd(4'h9, rd_val); chk("R6 reg9 mask", rd_val, 4'h1);
    bus_rd(4'h7, rd_val); chk("R6 reg7 mask", rd_val, 4'h3);
    bus_rd(4'h1, rd_val); chk("R6 reg1 mask", rd_val, 4'h7);

    s0 = stb_cnt; bus_wr(4'h2, 4'h5);
    chk("R10 time write while free", 4'(stb_cnt - s0), 4'h0);

    bus_wr(4'hD, 4'hF);
    bus_rd(4'hD, rd_val); chk("R8 busy in window", rd_val, 4'hF);
    upd_win = 1'b0; cyc(3);
    bus_rd(4'hD, rd_val); chk("R8 busy cleared", rd_val, 4'hD);

    s0 = stb_cnt; bus_wr(4'h1, 4'hF);
    chk("R10 time write while held", 4'(stb_cnt - s0), 4'h1);

    c0 = carry_cnt;
    tick_1s = 1'b1; cyc(1); tick_1s = 1'b0; cyc(5);
    tick_1s = 1'b1; cyc(1); tick_1s = 1'b0; cyc(5);
    chk("R7 no carry during hold", 4'(carry_cnt - c0), 4'h0);
    bus_wr(4'hD, 4'hC); cyc(2);
    chk("R7 single deferred carry", 4'(carry_cnt - c0), 4'h1);
    tick_1s = 1'b1; cyc(1); tick_1s = 1'b0; cyc(2);
    chk("R7 live carry", 4'(carry_cnt - c0), 4'h2);

    s0 = stb_cnt;
    bus_a = 4'hE; bus_din = 4'h3; wr_n = 1'b0; rd_n = 1'b0; cyc(4);
    @(negedge clk); chk("R5 doe off in conflict", {3'b0, bus_doe}, 4'h0);
    cyc(1); wr_n = 1'b1; cyc(4); rd_n = 1'b1; cyc(3);
    chk("R5 write dropped", 4'(stb_cnt - s0), 4'h0);

    ale = 1'b1; bus_a = 4'h9; cs_lo_n = 1'b0; cyc(4);
    ale = 1'b0; cyc(4); bus_a = 4'h3; cs_lo_n = 1'b1;
    rd_n = 1'b0; cyc(3); @(negedge clk);
    chk("R2 latched addr read", bus_dout, 4'h1);
    chk("R2 latched select", {3'b0, bus_doe}, 4'h1);
    cyc(1); rd_n = 1'b1; cyc(3);
    ale = 1'b1; bus_a = 4'h9; cs_lo_n = 1'b1; cyc(4);
    ale = 1'b0; cyc(4); cs_lo_n = 1'b0;
    rd_n = 1'b0; cyc(3); @(negedge clk);
    chk("R1 deselected by latch", {3'b0, bus_doe}, 4'h0);
    cyc(1); rd_n = 1'b1; cyc(3);
    ale = 1'b1; cyc(4);

    bus_wr(4'hF, 4'h1); @(negedge clk);
    chk("R9 srst set", {3'b0, subsec_rst}, 4'h1);
    bus_wr(4'hD, 4'h1);
    cs_hi = 1'b0; cyc(5);
    chk("R9 srst cleared", {3'b0, subsec_rst}, 4'h0);
    s0 = stb_cnt; bus_wr(4'hE, 4'h7);
    chk("R1 no write while deselected", 4'(stb_cnt - s0), 4'h0);
    cs_hi = 1'b1; cyc(4);
    bus_rd(4'hD, rd_val); chk("R9 hold cleared", rd_val, 4'hE);

    cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule